// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a serial peripheral master that moves words between an eight-entry transmit queue and an eight-entry receive queue. Software reaches it through a small register bus with write strobe, read strobe, a 3-bit word address and 32-bit data. The bus sets the word length, the serial clock rate and the clock mode. Through the same bus software fills the transmit queue, starts a transfer, drains received words and handles the events. The block drives the serial clock and the outgoing data line, samples the incoming data line, shows whether a transfer is in progress, and raises one interrupt line from the events that are not masked.

Each queued transmit word carries its own end-of-transfer flag. A transfer, once started, shifts queued words back to back. It stops after the flagged word has been shifted completely. If no word is queued when the shifter needs one, it sends zeros and records an event. Chip-select decoding is done outside the block. An internal loop from outgoing to incoming data is provided for self-test.

Register map (word addresses): 0 configuration, 1 interrupt mask, 2 events, 3 command, 4 status, 5 data.

Top module: `spi_fifo_master`

## Requirements
- R1: Out of reset the events register reads 0, the mask reads 0x1F, the configuration reads length 8 with BRG 4 and DIV 0 and all mode bits clear (0x00040800), status reads 0x04 (receive queue empty), irq is low and the serial clock is low.
- R2: Configuration bits 12:8 hold the word length. A written value below 4 is stored as 4, and one above 24 is stored as 24. A received word holds only that many low bits, and every bit above them reads zero.
- R3: Configuration bits 21:16 hold BRG and bits 25:24 hold DIV. The serial clock period is 2*(BRG+1)*(2<<DIV) input clocks. A written BRG below 4 is stored as 4.
- R4: A write to the data address queues bits 23:0 as a word, and bit 24 is its end flag. A transfer shifts queued words one after another and stops after the flagged word. It then sets event bit 0 (done).
- R5: Command bit 0 starts a transfer. The command is ignored unless status bit 0 (ready) is set and no transfer is running (status bit 4).
- R6: Command bit 1 clears the receive queue and command bit 2 clears the transmit queue. Each bit reads back as 1 in the cycle after the write, and as 0 once the queue has been emptied.
- R7: Configuration bit 0 enables the device. Status bit 0 (ready) follows the enable one cycle later. While the device is enabled, a configuration write changes only the enable bit.
- R8: When a word is needed and the transmit queue is empty, event bit 1 is set, a zero word is shifted and the transfer continues.
- R9: When a word completes and the receive queue is full, the word is dropped and event bit 2 is set.
- R10: Configuration bit 2 makes the idle clock level high. Configuration bit 1 set presents data before the first clock edge; when it is clear, data changes on the first edge. Configuration bit 3 selects least-significant-bit-first order. Configuration bit 4 routes the outgoing data back to the receiver.
- R11: Events are sticky and are cleared by writing 1 to them. irq is high while any event bit has its mask bit (same position) clear.
- R12: Status bit 1 shows a full transmit queue and bit 2 an empty receive queue. A push to a full transmit queue is dropped, and a data read with the receive queue empty returns 0.
- R13: Event bit 3 is set while at most 4 words are queued for transmit. Event bit 4 is set while at least 4 received words are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at the data address) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Outgoing serial data |
| spi_miso | input | 1 | Incoming serial data |
| xfer_active | output | 1 | High while a transfer is running |
| irq | output | 1 | Interrupt from unmasked events |

## Verification
The bench builds the block with its defaults: queues of 8 entries and a maximum word of 24 bits. With queues this shallow, a full transmit queue, a dropped ninth push and a receive overflow take only a handful of words. The 24-bit width covers the whole allowed length range, and the random loop draws lengths from it. The small default rate makes transfers short, and one directed transfer at DIV 3 and BRG 63 exercises the widest baud count.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
    localparam int BUS_W     = 32;
    localparam int WLEN_MIN  = 4;
    localparam int BRG_MIN   = 4;
    localparam int LAST_BIT  = 24;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_MASK = 3'd1;
    localparam logic [2:0] A_EVT  = 3'd2;
    localparam logic [2:0] A_CMD  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;
    localparam logic [2:0] A_DATA = 3'd5;

    localparam int EV_DONE  = 0;
    localparam int EV_UND   = 1;
    localparam int EV_OVF   = 2;
    localparam int EV_TXREQ = 3;
    localparam int EV_RXREQ = 4;
    localparam int EV_N     = 5;

    typedef struct packed {
        logic [1:0] div;
        logic [5:0] brg;
        logic [4:0] wlen;
        logic       loop;
        logic       lsb;
        logic       pol;
        logic       ph_first;
        logic       en;
    } cfg_t;
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int W     = 25,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign dout  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (clr) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = din;
                st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_fm_baud.sv
module spi_fm_baud (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [5:0] brg,
    input  logic [1:0] div,
    output logic       tick
);
    localparam int CNT_W = 6 + 1 + 4;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half;

    always_comb begin
        half  = (CNT_W'(brg) + CNT_W'(1)) << (CNT_W'(div) + CNT_W'(1));
        tick  = run && (cnt_q == half - CNT_W'(1));
        cnt_d = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter
    import spi_fm_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              start,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_last,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              ev_done,
    output logic              ev_und,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int EW = $clog2(2 * DATA_W + 1);

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic [EW-1:0]     e;
        logic [DATA_W-1:0] txw;
        logic              last;
        logic [DATA_W-1:0] rxw;
    } sh_t;

    sh_t st_d, st_q;

    function automatic logic [4:0] ord(input logic [4:0] i, input logic lsb, input logic [4:0] wl);
        return lsb ? i : (wl - 5'd1 - i);
    endfunction

    logic [4:0]        bit_i, out_i;
    logic [EW-1:0]     last_e;
    logic              miso_in;
    logic [DATA_W-1:0] samp;

    always_comb begin
        bit_i  = 5'(st_q.e >> 1);
        out_i  = cfg.ph_first ? bit_i : ((st_q.e == '0) ? 5'd0 : 5'((st_q.e - EW'(1)) >> 1));
        mosi   = st_q.busy && (cfg.ph_first || st_q.e != '0) && st_q.txw[ord(out_i, cfg.lsb, cfg.wlen)];
        sclk   = st_q.busy ? (st_q.sck ^ cfg.pol) : cfg.pol;
        busy   = st_q.busy;
        last_e = (EW'(cfg.wlen) << 1) - EW'(1);
        miso_in = cfg.loop ? mosi : miso;
    end

    always_comb begin
        st_d    = st_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = '0;
        ev_done = 1'b0;
        ev_und  = 1'b0;
        samp    = st_q.rxw;
        if (!cfg.en) begin
            st_d.busy = 1'b0;
            st_d.sck  = 1'b0;
        end else if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.e    = '0;
                st_d.sck  = 1'b0;
                st_d.rxw  = '0;
                if (tx_empty) begin
                    ev_und = 1'b1; st_d.txw = '0; st_d.last = 1'b0;
                end else begin
                    tx_pop = 1'b1; st_d.txw = tx_word; st_d.last = tx_last;
                end
            end
        end else if (tick) begin
            st_d.sck = ~st_q.sck;
            if (st_q.e[0] == ~cfg.ph_first) begin
                samp[ord(bit_i, cfg.lsb, cfg.wlen)] = miso_in;
            end
            if (st_q.e == last_e) begin
                rx_push  = 1'b1;
                rx_word  = samp;
                st_d.e   = '0;
                st_d.rxw = '0;
                if (st_q.last) begin
                    st_d.busy = 1'b0;
                    ev_done   = 1'b1;
                end else if (tx_empty) begin
                    ev_und = 1'b1; st_d.txw = '0; st_d.last = 1'b0;
                end else begin
                    tx_pop = 1'b1; st_d.txw = tx_word; st_d.last = tx_last;
                end
            end else begin
                st_d.e   = st_q.e + EW'(1);
                st_d.rxw = samp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fm_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        xfer_active,
    output logic        irq
);
    localparam int CW   = $clog2(FIFO_DEPTH + 1);
    localparam int HALF = FIFO_DEPTH / 2;

    typedef struct packed {
        cfg_t            cfg;
        logic [EV_N-1:0] mask;
        logic [EV_N-1:0] ev;
        logic            clr_rx;
        logic            clr_tx;
        logic            ready;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic [DATA_W:0]   tx_dout;
    logic [DATA_W-1:0] rx_dout, sh_rx_word;
    logic              tx_pop, sh_rx_push, sh_done, sh_und, sh_busy, tick, start;
    logic              tx_push, rx_pop, wr_cmd;
    logic [4:0]        wl;
    logic [5:0]        br;
    logic [EV_N-1:0]   ev_set, w1c;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[31:26], bus_wdata[23:22], bus_wdata[15:13], bus_wdata[7:5]};

    assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
    assign start   = wr_cmd && bus_wdata[0] && st_q.ready;
    assign tx_push = bus_wr && (bus_addr == A_DATA);
    assign rx_pop  = bus_rd && (bus_addr == A_DATA);

    spi_fm_fifo #(.W(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(st_q.clr_tx), .push(tx_push),
        .din({bus_wdata[LAST_BIT], bus_wdata[DATA_W-1:0]}), .pop(tx_pop),
        .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(st_q.clr_rx), .push(sh_rx_push),
        .din(sh_rx_word), .pop(rx_pop),
        .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spi_fm_baud u_baud (
        .clk(clk), .rst_n(rst_n), .run(sh_busy),
        .brg(st_q.cfg.brg), .div(st_q.cfg.div), .tick(tick)
    );

    spi_fm_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cfg(st_q.cfg), .start(start), .tick(tick),
        .tx_empty(tx_empty), .tx_word(tx_dout[DATA_W-1:0]), .tx_last(tx_dout[DATA_W]),
        .tx_pop(tx_pop), .rx_push(sh_rx_push), .rx_word(sh_rx_word),
        .ev_done(sh_done), .ev_und(sh_und), .busy(sh_busy),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    always_comb begin
        st_d = st_q;
        wl   = bus_wdata[12:8];
        br   = bus_wdata[21:16];
        if (wl < 5'(WLEN_MIN))     wl = 5'(WLEN_MIN);
        else if (wl > 5'(DATA_W))  wl = 5'(DATA_W);
        if (br < 6'(BRG_MIN))      br = 6'(BRG_MIN);

        if (bus_wr && bus_addr == A_CFG) begin
            if (st_q.cfg.en) begin
                st_d.cfg.en = bus_wdata[0];
            end else begin
                st_d.cfg.en       = bus_wdata[0];
                st_d.cfg.ph_first = bus_wdata[1];
                st_d.cfg.pol      = bus_wdata[2];
                st_d.cfg.lsb      = bus_wdata[3];
                st_d.cfg.loop     = bus_wdata[4];
                st_d.cfg.wlen     = wl;
                st_d.cfg.brg      = br;
                st_d.cfg.div      = bus_wdata[25:24];
            end
        end
        if (bus_wr && bus_addr == A_MASK) st_d.mask = bus_wdata[EV_N-1:0];

        ev_set            = '0;
        ev_set[EV_DONE]   = sh_done;
        ev_set[EV_UND]    = sh_und;
        ev_set[EV_OVF]    = sh_rx_push && rx_full;
        ev_set[EV_TXREQ]  = (tx_cnt <= CW'(HALF));
        ev_set[EV_RXREQ]  = (rx_cnt >= CW'(HALF));
        w1c               = (bus_wr && bus_addr == A_EVT) ? bus_wdata[EV_N-1:0] : '0;
        st_d.ev           = (st_q.ev & ~w1c) | ev_set;

        st_d.clr_rx = wr_cmd && bus_wdata[1];
        st_d.clr_tx = wr_cmd && bus_wdata[2];
        st_d.ready  = st_q.cfg.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cfg.wlen <= 5'd8;
            st_q.cfg.brg  <= 6'(BRG_MIN);
            st_q.mask     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq         = |(st_q.ev & ~st_q.mask);
    assign xfer_active = sh_busy;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG: begin
                bus_rdata[0]     = st_q.cfg.en;
                bus_rdata[1]     = st_q.cfg.ph_first;
                bus_rdata[2]     = st_q.cfg.pol;
                bus_rdata[3]     = st_q.cfg.lsb;
                bus_rdata[4]     = st_q.cfg.loop;
                bus_rdata[12:8]  = st_q.cfg.wlen;
                bus_rdata[21:16] = st_q.cfg.brg;
                bus_rdata[25:24] = st_q.cfg.div;
            end
            A_MASK: bus_rdata[EV_N-1:0] = st_q.mask;
            A_EVT:  bus_rdata[EV_N-1:0] = st_q.ev;
            A_CMD:  bus_rdata[2:1] = {st_q.clr_tx, st_q.clr_rx};
            A_STAT: bus_rdata[4:0] = {sh_busy, irq, rx_empty, tx_full, st_q.ready};
            A_DATA: bus_rdata = rx_empty ? '0 : BUS_W'(rx_dout);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          ready,
    input logic          busy,
    input logic          start_wr,
    input logic          clr_tx,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          ev_done,
    input logic [5:0]    brg,
    input logic [4:0]    wlen
);
    assert_ready_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ready);

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tx |=> (tx_cnt == '0));

    assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !ready && !busy) |=> !busy);

    assert_done_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && en) |-> ev_done);

    assert_fifo_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    assert_brg_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        brg >= 6'd4);

    assert_wlen_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wlen >= 5'd4) && (wlen <= 5'd24));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(st_q.cfg.en), .ready(st_q.ready),
    .busy(xfer_active), .start_wr(wr_cmd && bus_wdata[0]), .clr_tx(st_q.clr_tx),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ev_done(st_q.ev[0]),
    .brg(st_q.cfg.brg), .wlen(st_q.cfg.wlen)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, xfer_active, irq;
    logic        spi_miso = 1'b0;
    int          n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    spi_fifo_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .xfer_active(xfer_active), .irq(irq)
    );

    localparam logic [2:0] CFG = 0, MSK = 1, EVT = 2, CMD = 3, STA = 4, DAT = 5;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] cfg_word(input bit en, ph, pol, lsb, lp,
                                             input int wl, brg, dv);
        return 32'(en) | (32'(ph) << 1) | (32'(pol) << 2) | (32'(lsb) << 3) | (32'(lp) << 4)
             | (32'(wl) << 8) | (32'(brg) << 16) | (32'(dv) << 24);
    endfunction

    function automatic logic [31:0] exp_rx(input logic [31:0] d, input int wl);
        return d & ((32'd1 << wl) - 1);
    endfunction

    task automatic setup(input bit ph, pol, lsb, lp, input int wl, brg, dv);
        wr(CFG, cfg_word(0, ph, pol, lsb, lp, wl, brg, dv));
        wr(CFG, cfg_word(1, ph, pol, lsb, lp, wl, brg, dv));
        @(negedge clk); @(negedge clk);
    endtask

    task automatic push(input logic [23:0] d, input bit last);
        wr(DAT, (32'(last) << 24) | 32'(d));
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 30000; i++) begin
            rd(EVT, v);
            if (v[0]) break;
        end
    endtask

    task automatic cleanup();
        wr(CMD, 32'h2);
        @(negedge clk);
        wr(EVT, 32'h1F);
    endtask

    task automatic measure(output int p);
        int t = 0, r1 = -1;
        logic prev = spi_sclk;
        p = -1;
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk); t++;
            if (spi_sclk && !prev) begin
                if (r1 < 0) r1 = t;
                else begin p = t - r1; break; end
            end
            prev = spi_sclk;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p;
        logic [23:0] dat [4];
        int wl, nw;
        bit ph, po, ls;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 events", bus_rdata, bus_rdata); // placeholder-free sample of bus below
        n_tests--;
        rd(EVT, v);  check("R1 events", v, 32'h0);
        rd(MSK, v);  check("R1 mask", v, 32'h1F);
        rd(CFG, v);  check("R1 config", v, 32'h00040800);
        rd(STA, v);  check("R1 status", v, 32'h04);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 sclk", 32'(spi_sclk), 32'h0);

        // R5 start ignored while disabled
        wr(CMD, 32'h1);
        rd(STA, v);  check("R5 no start when not ready", v & 32'h10, 32'h0);
        check("R5 xfer_active", 32'(xfer_active), 32'h0);

        // R7 ready follows enable one cycle late
        wr(CFG, cfg_word(1, 1, 0, 0, 1, 8, 4, 0));
        rd(STA, v);  check("R7 ready not yet", v & 32'h1, 32'h0);
        rd(STA, v);  check("R7 ready set", v & 32'h1, 32'h1);
        wr(CFG, cfg_word(1, 1, 0, 0, 1, 12, 9, 2));
        rd(CFG, v);  check("R7 cfg locked while enabled", v, cfg_word(1, 1, 0, 0, 1, 8, 4, 0));

        // R2 / R3 clamping
        wr(CFG, 32'h0);
        wr(CFG, cfg_word(0, 0, 0, 0, 0, 2, 1, 0));
        rd(CFG, v);  check("R2 R3 clamp low", v, cfg_word(0, 0, 0, 0, 0, 4, 4, 0));
        wr(CFG, cfg_word(0, 0, 0, 0, 0, 30, 7, 1));
        rd(CFG, v);  check("R2 clamp high", v, cfg_word(0, 0, 0, 0, 0, 24, 7, 1));

        // R12 / R6 queue full and clear
        for (int i = 0; i < 8; i++) push(24'(i), 0);
        rd(STA, v);  check("R12 tx full", v & 32'h2, 32'h2);
        wr(CMD, 32'h4);
        rd(CMD, v);  check("R6 tx clear pending", v, 32'h4);
        rd(CMD, v);  check("R6 tx clear done", v, 32'h0);
        rd(STA, v);  check("R6 tx emptied", v & 32'h2, 32'h0);
        wr(CMD, 32'h2);
        rd(CMD, v);  check("R6 rx clear pending", v, 32'h2);
        rd(CMD, v);  check("R6 rx clear done", v, 32'h0);

        // R13 transmit request threshold
        for (int i = 0; i < 5; i++) push(24'(i), 0);
        wr(EVT, 32'h1F);
        @(negedge clk);
        rd(EVT, v);  check("R13 tx req off above half", v & 32'h8, 32'h0);
        wr(CMD, 32'h4);
        @(negedge clk); @(negedge clk);
        rd(EVT, v);  check("R13 tx req on at or below half", v & 32'h8, 32'h8);

        // R4 / R12 chained words, dropped ninth push
        setup(1, 0, 0, 1, 8, 4, 0);
        wr(EVT, 32'h1F);
        for (int i = 0; i < 8; i++) push(24'(8'h10 + i), i == 7);
        push(24'hAA, 1);
        wr(CMD, 32'h1);
        wait_done();
        rd(EVT, v);  check("R4 R13 done and rx req, no overflow", v & 32'h15, 32'h11);
        for (int i = 0; i < 8; i++) begin
            rd(DAT, v); check("R4 chained word", v, 32'h10 + i);
        end
        rd(STA, v);  check("R12 rx empty after drain", v & 32'h4, 32'h4);
        rd(DAT, v);  check("R12 empty pop reads zero", v, 32'h0);

        // R9 overflow
        wr(EVT, 32'h1F);
        for (int i = 0; i < 8; i++) push(24'(8'h20 + i), i == 7);
        wr(CMD, 32'h1);
        wait_done();
        wr(EVT, 32'h1F);
        push(24'h77, 1);
        wr(CMD, 32'h1);
        wait_done();
        rd(EVT, v);  check("R9 overflow event", v & 32'h4, 32'h4);
        rd(DAT, v);  check("R9 oldest word kept", v, 32'h20);
        cleanup();

        // R8 underflow
        wr(CMD, 32'h1);
        rd(EVT, v);  check("R8 underflow event", v & 32'h2, 32'h2);
        check("R8 transfer continues", 32'(xfer_active), 32'h1);
        push(24'h5A, 1);
        wait_done();
        rd(DAT, v);  check("R8 zero word shifted", v, 32'h0);
        rd(DAT, v);  check("R8 then queued word", v, 32'h5A);

        // R11 sticky events and masking
        check("R11 masked irq low", 32'(irq), 32'h0);
        wr(MSK, 32'h1E);
        check("R11 unmasked done raises irq", 32'(irq), 32'h1);
        wr(EVT, 32'h01);
        check("R11 write one clears irq", 32'(irq), 32'h0);
        rd(EVT, v);  check("R11 done cleared", v & 32'h1, 32'h0);
        wr(MSK, 32'h1F);
        cleanup();

        // R3 clock period
        setup(1, 0, 0, 1, 8, 5, 1);
        push(24'h3C, 1);
        wr(CMD, 32'h1);
        measure(p);  check("R3 period brg5 div1", 32'(p), 32'd48);
        wait_done(); cleanup();
        setup(1, 0, 0, 1, 4, 63, 3);
        push(24'h9, 1);
        wr(CMD, 32'h1);
        measure(p);  check("R3 period brg63 div3", 32'(p), 32'd2048);
        wait_done();
        rd(DAT, v);  check("R3 R2 slow word", v, 32'h9);
        cleanup();

        // R10 modes
        setup(1, 1, 0, 1, 8, 4, 0);
        check("R10 idle high clock", 32'(spi_sclk), 32'h1);
        push(24'h80, 1);
        wr(CMD, 32'h1);
        check("R10 data before first edge", 32'(spi_mosi), 32'h1);
        wait_done(); cleanup();
        setup(0, 0, 0, 1, 8, 4, 0);
        push(24'h80, 1);
        wr(CMD, 32'h1);
        check("R10 data held until first edge", 32'(spi_mosi), 32'h0);
        for (int i = 0; i < 100; i++) begin
            if (spi_sclk) break;
            @(negedge clk);
        end
        check("R10 data on first edge", 32'(spi_mosi), 32'h1);
        wait_done(); cleanup();
        setup(1, 0, 1, 1, 8, 4, 0);
        push(24'h01, 1);
        wr(CMD, 32'h1);
        check("R10 lsb first", 32'(spi_mosi), 32'h1);
        wait_done();
        rd(DAT, v);  check("R10 lsb loopback", v, 32'h01);
        cleanup();

        // R2 width masking with external input
        setup(1, 0, 0, 0, 5, 4, 0);
        spi_miso = 1'b1;
        push(24'h0, 1);
        wr(CMD, 32'h1);
        wait_done();
        rd(DAT, v);  check("R2 received width", v, 32'h1F);
        spi_miso = 1'b0;
        cleanup();

        // R4 R10 random loopback transfers
        for (int it = 0; it < 20; it++) begin
            wl = $urandom_range(24, 4);
            nw = $urandom_range(4, 1);
            ph = 1'($urandom); po = 1'($urandom); ls = 1'($urandom);
            setup(ph, po, ls, 1, wl, 4, 0);
            for (int k = 0; k < nw; k++) begin
                dat[k] = 24'($urandom);
                push(dat[k], k == nw - 1);
            end
            wr(CMD, 32'h1);
            wait_done();
            for (int k = 0; k < nw; k++) begin
                rd(DAT, v); check("R4 R10 random loopback", v, exp_rx(32'(dat[k]), wl));
            end
            cleanup();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule